// File: doc/BRIEF.md
# Third-Order Three-Level Sigma-Delta Modulator

This block turns a constant fractional control word into a stream of small integer corrections for a fractional-N divider. On every reference clock it emits a level of 0, 1 or 2, and the divider adds that level to its integer ratio. Averaged over many cycles, the stream equals the control word. The quantization error is pushed toward high frequencies by a third-order loop, where the PLL filter removes it.

The loop is a single stage. It has three accumulators in a chain, and each one carries a register between its input and its output, so no combinational path runs through two of them. The quantizer looks at a weighted sum of the three accumulator states. Each state is cut to a few fractional bits before the weighting, which keeps that adder narrow. The weights are 36/64, 11/64 and 1/64, which gives a noise transfer function of (1-z^-1)^3/(1-0.75z^-1)^3. The chosen level is scaled to the accumulator format and subtracted at the input of every accumulator. With three levels, any constant input from 0.5 to 1.5 keeps the loop in its stable region.

Top module: `sdm3_modulator`

## Requirements
- R1: `frac_i` is unsigned, with 1 integer bit and 15 fractional bits (0x8000 = 1.0). A word below 0x4000 acts exactly like 0x4000, and a word above 0xC000 acts exactly like 0xC000.
- R2: `lvl_o` only ever takes the codes 0, 1 and 2. The code 3 never appears.
- R3: With a constant input held and a window of N >= 4096 cycles taken after 256 settling cycles, the sum of `lvl_o` over the window is within 16 of N times the clamped input divided by 32768.
- R4: While `rst_ni` is low, `lvl_o` is 0 and `valid_o` is 0 at once, without waiting for a clock edge.
- R5: `valid_o` goes high on the first rising clock edge after reset is released and stays high until the next reset.
- R6: All accumulators start at zero after reset. The quantizer returns 0 below a weighted sum of 0.5, 1 from 0.5 up to but not including 1.5, and 2 at 1.5 and above. As a result, the first four valid outputs after reset are 0,1,1,1 for input 0x8000, 0,0,1,0 for input 0x4000, and 0,1,1,2 for input 0xC000.
- R7: No accumulator overflows for any constant input in range. Each state keeps at least four guard bits that copy its sign bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frac_i | input | IN_W | Fractional control word, 1.15 unsigned |
| lvl_o | output | 2 | Quantized level, 0 to 2, added to the integer divide value |
| valid_o | output | 1 | High once `lvl_o` holds a computed level |

## Verification
Some properties are checked by assertions on every cycle:
- every accumulator keeps its sign guard bits;
- the first accumulator moves by no more than 1.5 per cycle, which holds only if the input is clamped and the feedback is subtracted;
- `valid_o` never drops outside reset;
- the first valid level is 0.

Other behaviour only the bench scenarios can show. These cover the exact start-up sequences, which pin down the thresholds, the weights and the register delays in each accumulator. They also cover the long-run mean matching the clamped input at the range ends, in the middle and beyond the clamp limits, and the asynchronous clearing of the outputs during reset.

// File: rtl/sdm3_pkg.sv
package sdm3_pkg;
  localparam int IN_W    = 16;  // control word width
  localparam int IN_F    = 15;  // fractional bits of control word and states
  localparam int ACC_W   = 32;  // accumulator width, two's complement
  localparam int KEEP_F  = 6;   // fractional bits kept at the quantizer adder
  localparam int GUARD   = 4;   // sign guard bits checked on each state
  localparam int ORDER   = 3;
  localparam int COEF_SH = 6;
  // NTF poles at 0.75 (triple): weights 36/64, 11/64, 1/64
  localparam int COEF_NUM [ORDER] = '{36, 11, 1};
endpackage

// File: rtl/sdm3_clamp.sv
module sdm3_clamp #(
  parameter int IN_W = 16,
  parameter int IN_F = 15
) (
  input  logic [IN_W-1:0] din_i,
  output logic [IN_W-1:0] dout_o
);
  localparam logic [IN_W-1:0] LIM_LO = IN_W'(1) << (IN_F - 1);
  localparam logic [IN_W-1:0] LIM_HI = IN_W'(3) << (IN_F - 1);

  always_comb begin
    if (din_i < LIM_LO)      dout_o = LIM_LO;
    else if (din_i > LIM_HI) dout_o = LIM_HI;
    else                     dout_o = din_i;
  end
endmodule

// File: rtl/sdm3_integ.sv
module sdm3_integ #(
  parameter int ACC_W = 32,
  parameter int GUARD = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ACC_W-1:0] add_i,
  input  logic signed [ACC_W-1:0] sub_i,
  output logic signed [ACC_W-1:0] state_o
);
  logic signed [ACC_W-1:0] state_q;

  // delaying accumulator: output is last cycle's sum
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_q + add_i - sub_i;
  end

  assign state_o = state_q;

  // R7: sign guard bits intact
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(state_q[ACC_W-1 -: GUARD+1]) == 0) ||
    ($countones(state_q[ACC_W-1 -: GUARD+1]) == GUARD + 1));
endmodule

// File: rtl/sdm3_quant.sv
module sdm3_quant import sdm3_pkg::*; #(
  parameter int ACC_W  = 32,
  parameter int IN_F   = 15,
  parameter int KEEP_F = 6
) (
  input  logic signed [ACC_W-1:0] st_i [ORDER],
  output logic [1:0]              lvl_o
);
  localparam int DROP  = IN_F - KEEP_F;
  localparam int TR_W  = ACC_W - DROP;
  localparam int SUM_W = TR_W + COEF_SH + 2;
  localparam logic signed [SUM_W-1:0] TH_LO = SUM_W'(1) <<< (KEEP_F + COEF_SH - 1);
  localparam logic signed [SUM_W-1:0] TH_HI = SUM_W'(3) <<< (KEEP_F + COEF_SH - 1);

  logic signed [SUM_W-1:0] term [ORDER];
  logic signed [SUM_W-1:0] sum_c;

  for (genvar i = 0; i < ORDER; i++) begin : g_term
    logic signed [TR_W-1:0] tr;
    logic                   unused_lo;
    assign tr        = st_i[i][ACC_W-1:DROP];  // truncated operand
    assign unused_lo = ^st_i[i][DROP-1:0];
    assign term[i]   = SUM_W'(tr) * SUM_W'(COEF_NUM[i]);
  end

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < ORDER; i++) sum_c = sum_c + term[i];
  end

  always_comb begin
    if (sum_c < TH_LO)      lvl_o = 2'd0;
    else if (sum_c < TH_HI) lvl_o = 2'd1;
    else                    lvl_o = 2'd2;
  end
endmodule

// File: rtl/sdm3_modulator.sv
module sdm3_modulator import sdm3_pkg::*; #(
  parameter int IN_W   = sdm3_pkg::IN_W,
  parameter int IN_F   = sdm3_pkg::IN_F,
  parameter int ACC_W  = sdm3_pkg::ACC_W,
  parameter int KEEP_F = sdm3_pkg::KEEP_F
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IN_W-1:0] frac_i,
  output logic [1:0]      lvl_o,
  output logic            valid_o
);
  localparam logic signed [ACC_W-1:0] STEP_MAX = ACC_W'(3) <<< (IN_F - 1);

  logic [IN_W-1:0]         frac_c;
  logic signed [ACC_W-1:0] st    [ORDER];
  logic signed [ACC_W-1:0] add_s [ORDER];
  logic signed [ACC_W-1:0] fb_s;
  logic [1:0]              lvl_c;

  sdm3_clamp #(.IN_W(IN_W), .IN_F(IN_F)) u_clamp (
    .din_i (frac_i),
    .dout_o(frac_c)
  );

  assign fb_s = ACC_W'(lvl_c) << IN_F;

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign add_s[i] = ACC_W'(frac_c);
    end else begin : g_chain
      assign add_s[i] = st[i-1];
    end
    sdm3_integ #(.ACC_W(ACC_W), .GUARD(GUARD)) u_integ (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .add_i  (add_s[i]),
      .sub_i  (fb_s),
      .state_o(st[i])
    );
  end

  sdm3_quant #(.ACC_W(ACC_W), .IN_F(IN_F), .KEEP_F(KEEP_F)) u_quant (
    .st_i (st),
    .lvl_o(lvl_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o   <= 2'd0;
      valid_o <= 1'b0;
    end else begin
      lvl_o   <= lvl_c;
      valid_o <= 1'b1;
    end
  end

  // R5: valid stays high outside reset
  p_valid_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> valid_o);

  // R6: zero states give level 0 first
  p_first_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (lvl_o == 2'd0));

  // R3: first accumulator moves by clamped input minus feedback, never beyond 1.5
  p_acc_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st[0] - $past(st[0])) <= STEP_MAX) && ((st[0] - $past(st[0])) >= -STEP_MAX));
endmodule

// File: tb/sdm3_modulator_tb.sv
module sdm3_modulator_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NV     = 8;
  localparam int SETTLE = 256;
  localparam int TOL    = 16;
  localparam int VEC_IN  [NV] = '{32'h8000, 32'h4000, 32'hC000, 32'h6000,
                                  32'hA3D7, 32'h1000, 32'hFFFF, 32'h0000};
  localparam int VEC_EXP [NV] = '{32'h8000, 32'h4000, 32'hC000, 32'h6000,
                                  32'hA3D7, 32'h4000, 32'hC000, 32'h4000};
  localparam int VEC_LEN [NV] = '{8192, 8192, 8192, 65536, 8192, 8192, 8192, 8192};

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] frac = 16'h8000;
  logic [1:0]  lvl;
  logic        valid;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sdm3_modulator u_dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .frac_i (frac),
    .lvl_o  (lvl),
    .valid_o(valid)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // reset, release, then compare first four valid levels (R6)
  task automatic start_seq(input logic [15:0] v, input int e0, input int e1,
                           input int e2, input int e3);
    int exp_l [4];
    exp_l = '{e0, e1, e2, e3};
    @(negedge clk);
    rst_ni = 1'b0;
    frac   = v;
    @(negedge clk);
    check(lvl == 2'd0 && valid == 1'b0, "R4 outputs held in reset", {lvl, valid}, 0);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) check(valid == 1'b1, "R5 valid after first edge", valid, 1);
      check(lvl == exp_l[k], $sformatf("R6 start level %0d input %h", k, v), lvl, exp_l[k]);
    end
  endtask

  task automatic run_vec(input int i);
    longint sum = 0;
    int     bad = 0;
    longint act_s, exp_s, diff;
    @(negedge clk);
    frac = VEC_IN[i][15:0];
    repeat (SETTLE) @(negedge clk);
    for (int c = 0; c < VEC_LEN[i]; c++) begin
      @(negedge clk);
      sum += longint'(lvl);
      if (lvl == 2'd3) bad++;
    end
    act_s = sum * 32768;
    exp_s = longint'(VEC_EXP[i]) * longint'(VEC_LEN[i]);
    diff  = (act_s > exp_s) ? act_s - exp_s : exp_s - act_s;
    check(diff <= longint'(TOL) * 32768,
          (VEC_IN[i] != VEC_EXP[i]) ? $sformatf("R1 clamped mean input %h", VEC_IN[i])
                                    : $sformatf("R3 mean input %h", VEC_IN[i]),
          sum, exp_s / 32768);
    check(bad == 0, $sformatf("R2 code 3 count input %h", VEC_IN[i]), bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(lvl == 2'd0, "R4 level at power-up reset", lvl, 0);
    check(valid == 1'b0, "R4 valid at power-up reset", valid, 0);

    start_seq(16'h8000, 0, 1, 1, 1);
    start_seq(16'h4000, 0, 0, 1, 0);
    start_seq(16'hC000, 0, 1, 1, 2);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R5: valid held through long run
    check(valid == 1'b1, "R5 valid still high", valid, 1);

    // R4: asynchronous clear mid-run
    @(negedge clk);
    frac = 16'hC000;
    repeat (20) @(negedge clk);
    #1;
    rst_ni = 1'b0;
    #0.5;
    check(lvl == 2'd0, "R4 async clear level", lvl, 0);
    check(valid == 1'b0, "R4 async clear valid", valid, 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(valid == 1'b1 && lvl == 2'd0, "R6 first level after async reset", lvl, 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule